// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block holds the hazard control for a five-stage in-order pipeline with the stages fetch, decode/register read, execute, memory and write-back. It reads the register numbers and the few control bits held in the decode stage and in the three pipeline registers after it. From these it produces three kinds of output:

- the select codes for the two ALU operand multiplexers;
- a hold request that freezes the PC and the fetch/decode register, together with a bubble request for the decode/execute register;
- a squash request for the fetch/decode register when a branch resolved in decode is taken.

Results are forwarded from the memory-stage and write-back-stage registers, so a dependent instruction does not wait for write-back. A producer three instructions ahead needs no forwarding, because the register file writes in the first half of a cycle and reads in the second half. A load that is followed at once by a reader of its destination cannot be covered by forwarding. For that case the unit holds the reader in decode for exactly one cycle and sends a bubble into execute. Branches are predicted not taken. When a branch turns out to be taken, the one wrong-path instruction that was fetched is squashed.

A single state bit records whether the unit held the pipeline in the previous cycle. This bit guarantees that a load-use hold never lasts longer than one cycle.

Top module: `hazard_fwd_unit`

## Requirements
- R1: `alu_sel_a` is 2'b10 (memory-stage result) when `mem_wr_en` is 1, `mem_dst` is not 0 and `mem_dst` equals `ex_src_a`.
- R2: `alu_sel_a` is 2'b01 (write-back result) when `wb_wr_en` is 1, `wb_dst` is not 0, `wb_dst` equals `ex_src_a` and the R1 condition is false. The memory stage wins when both stages match.
- R3: `alu_sel_a` is 2'b00 (register file) when neither stage matches. A destination of register 0, or a stage whose write enable is 0, never counts as a match.
- R4: `alu_sel_b` follows R1 to R3 with `ex_src_b` in place of `ex_src_a`, independently of operand A.
- R5: `hold` and `bubble` are both 1 when `ex_is_load` is 1, `ex_dst` is not 0, `ex_dst` equals `id_src_a` or `id_src_b`, and `hold` was 0 in the previous cycle.
- R6: `hold` and `bubble` stay 0 when the instruction in execute is not a load, or when its destination is register 0, whatever the register numbers are.
- R7: `hold` is never 1 in two consecutive cycles, even if the load-use condition stays present.
- R8: `squash` is 1 when `id_br_taken` is 1 and `hold` is 0, and `squash` is 0 when `id_br_taken` is 0.
- R9: While `hold` is 1, `squash` is 0 even if `id_br_taken` is 1. The branch is held in decode and resolves again in the next cycle.
- R10: Reset (`rst_n` low) clears the previous-hold state, so the first load-use condition after reset raises `hold`. With all inputs 0, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| id_src_a | input | AW | First source register of the instruction in decode |
| id_src_b | input | AW | Second source register of the instruction in decode |
| id_br_taken | input | 1 | Branch in decode resolved as taken |
| ex_src_a | input | AW | First source register held in decode/execute |
| ex_src_b | input | AW | Second source register held in decode/execute |
| ex_dst | input | AW | Destination register held in decode/execute |
| ex_is_load | input | 1 | Instruction in execute reads data memory |
| mem_dst | input | AW | Destination register held in execute/memory |
| mem_wr_en | input | 1 | Execute/memory instruction writes a register |
| wb_dst | input | AW | Destination register held in memory/write-back |
| wb_wr_en | input | 1 | Memory/write-back instruction writes a register |
| alu_sel_a | output | 2 | Operand A select: 00 register file, 10 memory stage, 01 write-back stage |
| alu_sel_b | output | 2 | Operand B select, same encoding |
| hold | output | 1 | Freeze PC and fetch/decode register |
| bubble | output | 1 | Load a no-op into decode/execute |
| squash | output | 1 | Clear fetch/decode register after a taken branch |

## Verification
The bench targets the cases where both later stages write the same source register. A unit that gives write-back the priority there would hand the operand a stale value one instruction old. It drives register 0 and cleared write enables in every stage. A unit that matched these would forward garbage or raise a hold that is not needed. It keeps a load-use pattern present for two cycles, where a unit without the previous-hold bit would lock up. It also raises a taken branch during a hold, where squashing would throw away the branch that is still waiting in decode. Operand B is tested with patterns different from operand A, so that an operand swap or a shared match line is caught.

// File: rtl/hazard_fwd_pkg.sv
package hazard_fwd_pkg;

  // Operand multiplexer select codes; the datapath decodes these bit values.
  typedef enum logic [1:0] {
    SEL_REGFILE = 2'b00,
    SEL_WB      = 2'b01,
    SEL_MEM     = 2'b10
  } opnd_sel_e;

  localparam int unsigned N_OPND   = 2;  // ALU operands with a forwarding mux
  localparam int unsigned N_ID_SRC = 2;  // source fields read in decode

endpackage

// File: rtl/hz_opnd_sel.sv
module hz_opnd_sel
  import hazard_fwd_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic          mem_wr_en,
  input  logic [AW-1:0] mem_dst,
  input  logic          wb_wr_en,
  input  logic [AW-1:0] wb_dst,
  output opnd_sel_e     sel
);

  localparam logic [AW-1:0] ZERO_REG = '0;

  logic mem_hit;
  logic wb_hit;

  // A stage may supply the operand only when it writes a real register.
  assign mem_hit = mem_wr_en && (mem_dst != ZERO_REG) && (mem_dst == src);
  assign wb_hit  = wb_wr_en  && (wb_dst  != ZERO_REG) && (wb_dst  == src);

  // The younger result sits in the memory stage and must win.
  always_comb begin
    if (mem_hit) begin
      sel = SEL_MEM;
    end else if (wb_hit) begin
      sel = SEL_WB;
    end else begin
      sel = SEL_REGFILE;
    end
  end

endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int unsigned AW   = 5,
  parameter int unsigned NSRC = 2
) (
  input  logic [NSRC-1:0][AW-1:0] id_src,
  input  logic                    ex_is_load,
  input  logic [AW-1:0]           ex_dst,
  output logic                    hazard
);

  localparam logic [AW-1:0] ZERO_REG = '0;

  logic [NSRC-1:0] src_hit;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_src
      assign src_hit[g] = (id_src[g] == ex_dst);
    end
  endgenerate

  assign hazard = ex_is_load && (ex_dst != ZERO_REG) && (|src_hit);

endmodule

// File: rtl/hz_stall_ctl.sv
module hz_stall_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic load_hazard,
  input  logic br_taken,
  output logic hold,
  output logic bubble,
  output logic squash
);

  logic held_q;
  logic held_d;
  logic held_en;

  // A load-use hold lasts exactly one cycle.
  assign hold   = load_hazard && !held_q;
  assign bubble = hold;
  // The branch stays in decode during a hold, so it is not squashed yet.
  assign squash = br_taken && !hold;

  always_comb begin
    held_en = held_q || hold;
    held_d  = hold;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
    end else if (held_en) begin
      held_q <= held_d;
    end
  end

endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
  import hazard_fwd_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_src_a,
  input  logic [AW-1:0] id_src_b,
  input  logic          id_br_taken,
  input  logic [AW-1:0] ex_src_a,
  input  logic [AW-1:0] ex_src_b,
  input  logic [AW-1:0] ex_dst,
  input  logic          ex_is_load,
  input  logic [AW-1:0] mem_dst,
  input  logic          mem_wr_en,
  input  logic [AW-1:0] wb_dst,
  input  logic          wb_wr_en,
  output logic [1:0]    alu_sel_a,
  output logic [1:0]    alu_sel_b,
  output logic          hold,
  output logic          bubble,
  output logic          squash
);

  logic [N_OPND-1:0][AW-1:0]   ex_src;
  opnd_sel_e                   opnd_sel [N_OPND];
  logic [N_ID_SRC-1:0][AW-1:0] id_src;
  logic                        load_hazard;

  assign ex_src[0] = ex_src_a;
  assign ex_src[1] = ex_src_b;
  assign id_src[0] = id_src_a;
  assign id_src[1] = id_src_b;

  genvar g;
  generate
    for (g = 0; g < N_OPND; g++) begin : g_opnd
      hz_opnd_sel #(.AW(AW)) i_sel (
        .src       (ex_src[g]),
        .mem_wr_en (mem_wr_en),
        .mem_dst   (mem_dst),
        .wb_wr_en  (wb_wr_en),
        .wb_dst    (wb_dst),
        .sel       (opnd_sel[g])
      );
    end
  endgenerate

  assign alu_sel_a = opnd_sel[0];
  assign alu_sel_b = opnd_sel[1];

  hz_load_use #(.AW(AW), .NSRC(N_ID_SRC)) i_load_use (
    .id_src     (id_src),
    .ex_is_load (ex_is_load),
    .ex_dst     (ex_dst),
    .hazard     (load_hazard)
  );

  hz_stall_ctl i_stall (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_hazard (load_hazard),
    .br_taken    (id_br_taken),
    .hold        (hold),
    .bubble      (bubble),
    .squash      (squash)
  );

endmodule

// File: rtl/hazard_fwd_unit_chk.sv
module hazard_fwd_unit_chk #(
  parameter int unsigned AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] id_src_a,
  input logic [AW-1:0] id_src_b,
  input logic          id_br_taken,
  input logic [AW-1:0] ex_src_a,
  input logic [AW-1:0] ex_src_b,
  input logic [AW-1:0] ex_dst,
  input logic          ex_is_load,
  input logic [AW-1:0] mem_dst,
  input logic          mem_wr_en,
  input logic [AW-1:0] wb_dst,
  input logic          wb_wr_en,
  input logic [1:0]    alu_sel_a,
  input logic [1:0]    alu_sel_b,
  input logic          hold,
  input logic          bubble,
  input logic          squash
);

  localparam logic [AW-1:0] ZERO_REG = '0;

  p_mem_fwd_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && mem_dst != ZERO_REG && mem_dst == ex_src_a) |-> alu_sel_a == 2'b10);

  p_wb_fwd_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_wr_en && wb_dst != ZERO_REG && wb_dst == ex_src_b &&
     !(mem_wr_en && mem_dst != ZERO_REG && mem_dst == ex_src_b)) |-> alu_sel_b == 2'b01);

  p_no_writer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wr_en && !wb_wr_en) |-> (alu_sel_a == 2'b00 && alu_sel_b == 2'b00));

  p_hold_needs_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (ex_is_load && ex_dst != ZERO_REG));

  p_hold_bubble_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> bubble);

  p_single_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !hold);

  p_no_squash_in_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !squash);

  p_squash_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (id_br_taken && !hold) |-> squash);

endmodule

bind hazard_fwd_unit hazard_fwd_unit_chk #(.AW(AW)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .id_src_a    (id_src_a),
  .id_src_b    (id_src_b),
  .id_br_taken (id_br_taken),
  .ex_src_a    (ex_src_a),
  .ex_src_b    (ex_src_b),
  .ex_dst      (ex_dst),
  .ex_is_load  (ex_is_load),
  .mem_dst     (mem_dst),
  .mem_wr_en   (mem_wr_en),
  .wb_dst      (wb_dst),
  .wb_wr_en    (wb_wr_en),
  .alu_sel_a   (alu_sel_a),
  .alu_sel_b   (alu_sel_b),
  .hold        (hold),
  .bubble      (bubble),
  .squash      (squash)
);

// File: tb/test_hazard_fwd_unit.sv
module test_hazard_fwd_unit;

  localparam int unsigned AW = 5;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] id_src_a, id_src_b, ex_src_a, ex_src_b, ex_dst, mem_dst, wb_dst;
  logic          id_br_taken, ex_is_load, mem_wr_en, wb_wr_en;
  logic [1:0]    alu_sel_a, alu_sel_b;
  logic          hold, bubble, squash;

  int n_chk;
  int n_bad;

  hazard_fwd_unit #(.AW(AW)) i_hazard_fwd_unit (
    .clk(clk), .rst_n(rst_n),
    .id_src_a(id_src_a), .id_src_b(id_src_b), .id_br_taken(id_br_taken),
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .ex_dst(ex_dst), .ex_is_load(ex_is_load),
    .mem_dst(mem_dst), .mem_wr_en(mem_wr_en), .wb_dst(wb_dst), .wb_wr_en(wb_wr_en),
    .alu_sel_a(alu_sel_a), .alu_sel_b(alu_sel_b),
    .hold(hold), .bubble(bubble), .squash(squash)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  // Requirement model of one operand select (R1..R3).
  function automatic int ref_sel(input logic [AW-1:0] s, input logic mwe, input logic [AW-1:0] md,
                                 input logic wwe, input logic [AW-1:0] wd);
    if (mwe && md != 0 && md == s) return 2;
    if (wwe && wd != 0 && wd == s) return 1;
    return 0;
  endfunction

  task automatic clear_inputs();
    id_src_a = '0; id_src_b = '0; id_br_taken = 1'b0;
    ex_src_a = '0; ex_src_b = '0; ex_dst = '0; ex_is_load = 1'b0;
    mem_dst = '0; mem_wr_en = 1'b0; wb_dst = '0; wb_wr_en = 1'b0;
  endtask

  // Apply on falling edge, settle, then sample well before the rising edge.
  task automatic step_idle();
    @(negedge clk);
    clear_inputs();
    #5;
  endtask

  task automatic t_reset();
    clear_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #5;
    chk("R10", "sel_a after reset", alu_sel_a, 0);
    chk("R10", "sel_b after reset", alu_sel_b, 0);
    chk("R10", "hold after reset", hold, 0);
    chk("R10", "squash after reset", squash, 0);
    @(negedge clk);
    ex_is_load = 1; ex_dst = 5'd9; id_src_a = 5'd9;
    #5;
    chk("R10", "first hazard after reset", hold, 1);
    step_idle();
  endtask

  task automatic t_fwd_sweep();
    // R1 R2 R3 R4: sweep write enables and register matches on both operands
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      clear_inputs();
      mem_wr_en = i[0];
      wb_wr_en  = i[1];
      mem_dst   = i[2] ? 5'd3 : 5'd0;
      wb_dst    = i[3] ? 5'd3 : (i[4] ? 5'd0 : 5'd7);
      ex_src_a  = i[5] ? 5'd3 : 5'd7;
      ex_src_b  = i[5] ? 5'd7 : 5'd3;
      if (!i[2] && i[4]) ex_src_a = 5'd0;
      #5;
      chk("R1/R2/R3", "sweep sel_a", alu_sel_a, ref_sel(ex_src_a, mem_wr_en, mem_dst, wb_wr_en, wb_dst));
      chk("R4", "sweep sel_b", alu_sel_b, ref_sel(ex_src_b, mem_wr_en, mem_dst, wb_wr_en, wb_dst));
    end
  endtask

  task automatic t_fwd_directed();
    @(negedge clk);
    clear_inputs();
    mem_wr_en = 1; mem_dst = 5'd4; wb_wr_en = 1; wb_dst = 5'd4; ex_src_a = 5'd4;
    #5;
    chk("R2", "memory stage wins over write-back", alu_sel_a, 2);
    @(negedge clk);
    clear_inputs();
    wb_wr_en = 1; wb_dst = 5'd6; ex_src_a = 5'd6; mem_wr_en = 1; mem_dst = 5'd8;
    #5;
    chk("R2", "write-back only", alu_sel_a, 1);
    @(negedge clk);
    clear_inputs();
    mem_wr_en = 1; mem_dst = 5'd0; wb_wr_en = 1; wb_dst = 5'd0;
    #5;
    chk("R3", "register 0 never forwarded a", alu_sel_a, 0);
    chk("R3", "register 0 never forwarded b", alu_sel_b, 0);
    @(negedge clk);
    clear_inputs();
    mem_dst = 5'd12; ex_src_b = 5'd12; wb_wr_en = 1; wb_dst = 5'd12; ex_src_a = 5'd30;
    #5;
    chk("R4", "operand b from write-back when memory stage not writing", alu_sel_b, 1);
    chk("R4", "operand a untouched", alu_sel_a, 0);
  endtask

  task automatic t_load_use();
    step_idle();
    @(negedge clk);
    ex_is_load = 1; ex_dst = 5'd10; id_src_b = 5'd10; id_src_a = 5'd2;
    #5;
    chk("R5", "hold on source b match", hold, 1);
    chk("R5", "bubble on source b match", bubble, 1);
    step_idle();
    @(negedge clk);
    ex_is_load = 0; ex_dst = 5'd10; id_src_a = 5'd10;
    #5;
    chk("R6", "no hold for non-load producer", hold, 0);
    chk("R6", "no bubble for non-load producer", bubble, 0);
    @(negedge clk);
    ex_is_load = 1; ex_dst = 5'd0; id_src_a = 5'd0; id_src_b = 5'd0;
    #5;
    chk("R6", "no hold for load to register 0", hold, 0);
    @(negedge clk);
    ex_is_load = 1; ex_dst = 5'd11; id_src_a = 5'd1; id_src_b = 5'd2;
    #5;
    chk("R6", "no hold without match", hold, 0);
    step_idle();
  endtask

  task automatic t_single_hold();
    @(negedge clk);
    ex_is_load = 1; ex_dst = 5'd15; id_src_a = 5'd15;
    #5;
    chk("R7", "hold first cycle", hold, 1);
    @(negedge clk);
    #5;
    chk("R7", "hold released second cycle", hold, 0);
    chk("R7", "bubble released second cycle", bubble, 0);
    @(negedge clk);
    #5;
    chk("R7", "hold again third cycle", hold, 1);
    step_idle();
  endtask

  task automatic t_branch();
    @(negedge clk);
    id_br_taken = 1;
    #5;
    chk("R8", "squash on taken branch", squash, 1);
    @(negedge clk);
    id_br_taken = 0;
    #5;
    chk("R8", "no squash on not-taken branch", squash, 0);
    @(negedge clk);
    id_br_taken = 1; ex_is_load = 1; ex_dst = 5'd20; id_src_a = 5'd20;
    #5;
    chk("R9", "squash withheld during hold", squash, 0);
    chk("R9", "hold present", hold, 1);
    @(negedge clk);
    #5;
    chk("R9", "squash after hold ends", squash, 1);
    step_idle();
  endtask

  bit done = 0;

  initial begin
    n_chk = 0;
    n_bad = 0;
    t_reset();
    t_fwd_sweep();
    t_fwd_directed();
    t_load_use();
    t_single_hold();
    t_branch();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule